// File: doc/BRIEF.md
# 8-bit Arithmetic, Decimal-Adjust, Rotate and Bit Unit

This block is the combinational 8-bit datapath of a small accumulator-style processor. Each cycle it takes an operation group and a sub-code, a primary operand (the accumulator or the register named by the instruction), an optional second operand and the current flag byte. In the same cycle it returns the result byte, the new flag byte and a write-enable for the destination. The register file and 16-bit arithmetic live elsewhere. The sequencer writes `result` back only when `wr_en` is high, and it always takes `flags_out` as the new flag register.

Operations fall into five groups, selected by `op_grp`:
- The eight two-operand accumulator operations.
- A miscellaneous group: decimal adjust, complement, negate, set carry and complement carry.
- The four single-byte accumulator rotates.
- The prefixed shift/rotate group.
- Bit test, bit clear and bit set.

Undefined codes leave the operand and the flags untouched and suppress the write.

The flag byte places sign at bit 7, zero at bit 6, half-carry at bit 4, parity/overflow at bit 2, subtract at bit 1 and carry at bit 0. Bits 5 and 3 are always driven to 0.

Top module: `alu8_unit`

## Requirements
- R1: With `op_grp`=000, `op_sel` 000 adds and 001 adds with the incoming carry (flag bit 0). The result is the low 8 bits of the sum. The flags are set as follows: sign = result bit 7; zero = result is 0; half-carry = carry out of bit 3; bit 2 = signed overflow; subtract = 0; carry = carry out of bit 7.
- R2: With `op_grp`=000, `op_sel` 010 subtracts `opb` from `opa`, and 011 also subtracts the incoming carry. Half-carry and carry report a borrow out of bit 3 and out of bit 7. Bit 2 is signed overflow, and the subtract flag is 1. Sign and zero follow the result.
- R3: With `op_grp`=000, `op_sel` 100, 101 and 110 give AND, XOR and OR. Carry and subtract are cleared. Half-carry is 1 for AND only. Bit 2 is 1 when the result has an even number of ones.
- R4: `op_grp`=000 with `op_sel` 111 compares. It produces the flags and result of R2's plain subtraction, but `wr_en` is 0.
- R5: `op_grp`=001, `op_sel`=000 is decimal adjust. When the subtract flag is 0, it first adds 6 if the low nibble of `opa` exceeds 9 or half-carry is set. It then adds 0x60 if the upper part of that intermediate sum (bits 8..4, counting any carry out of bit 7) exceeds 9 or carry is set. Carry becomes the old carry OR the second correction, and half-carry becomes (low nibble of `opa` > 9).
- R6: On the same code with the subtract flag set, decimal adjust subtracts 6 when half-carry is set and 0x60 when carry is set. Carry and the subtract flag are kept, and half-carry becomes (old half-carry AND low nibble < 6). For both R5 and R6, sign and zero follow the result and bit 2 is even parity.
- R7: In `op_grp`=001, `op_sel` 001 inverts `opa` and sets half-carry and subtract, keeping the other flags. `op_sel` 010 yields 0 minus `opa` with the flags of R2.
- R8: In `op_grp`=001, `op_sel` 011 sets carry and 100 inverts carry. Both clear subtract. Half-carry becomes 0 for 011 and the old carry for 100. Sign, zero and bit 2 are kept, and `result` equals `opa`.
- R9: `op_grp`=010 rotates `opa` with `op_sel[1:0]` selecting the variant:
  - 00: circular left, bit 7 goes to carry and bit 0.
  - 01: circular right, bit 0 goes to carry and bit 7.
  - 10: left through carry.
  - 11: right through carry.
  Sign, zero and bit 2 are kept, and half-carry and subtract are cleared.
- R10: `op_grp`=011 shifts `opa` by `op_sel`:
  - 000, 001, 010, 011: the four rotates of R9.
  - 100: left with 0 in.
  - 101: right keeping bit 7.
  - 110: left with 1 in.
  - 111: right with 0 in.
  The outgoing bit goes to carry. Sign, zero and even parity follow the result, and half-carry and subtract are cleared.
- R11: `op_grp`=100 with `op_sel[1:0]`=01 tests bit `bit_idx` of `opa`. Zero is set when that bit is 0, half-carry is set and subtract is cleared. The other flags are kept, `result` equals `opa` and `wr_en` is 0.
- R12: `op_grp`=100 with `op_sel[1:0]`=10 clears, and with 11 sets, bit `bit_idx` of `opa`. The other bits are unchanged and the flags pass through.
- R13: Flag bits 5 and 3 of `flags_out` are always 0. The following codes return `opa` with the flags passed through and `wr_en` 0:
  - `op_grp` 101, 110 and 111.
  - `op_grp`=001 with `op_sel` above 100.
  - `op_grp`=100 with `op_sel[1:0]`=00.
  All other codes drive `wr_en` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_grp | input | 3 | Operation group |
| op_sel | input | 3 | Operation within the group |
| bit_idx | input | 3 | Bit number for the bit group |
| opa | input | 8 | Accumulator or register operand |
| opb | input | 8 | Second operand for the two-operand group |
| flags_in | input | 8 | Current flag byte |
| result | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| wr_en | output | 1 | High when `result` should be written back |

## Verification
The unit has no registers, so every output is due in the same cycle as the inputs that produce it, once combinational settling is complete. The bench changes the inputs on the falling clock edge and reads the outputs a quarter period later, well before the next rising edge, so no register stands between stimulus and check. A hand-worked vector table covers each corner named in the requirements. Sweeps then compare every operand value against a behavioural model written with integer arithmetic.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int W    = 8;
  localparam int IW   = $clog2(W);
  localparam int HB   = 4;              // half-carry boundary
  localparam int FS   = 7;
  localparam int FZ   = 6;
  localparam int FH   = 4;
  localparam int FP   = 2;
  localparam int FN   = 1;
  localparam int FC   = 0;
  localparam logic [W-1:0] FLAG_KEEP =
    W'((1 << FS) | (1 << FZ) | (1 << FH) | (1 << FP) | (1 << FN) | (1 << FC));

  typedef enum logic [2:0] {
    GRP_ACC   = 3'd0,
    GRP_MISC  = 3'd1,
    GRP_AROT  = 3'd2,
    GRP_SHIFT = 3'd3,
    GRP_BIT   = 3'd4
  } grp_e;

  typedef struct packed {
    logic [W-1:0] res;
    logic [W-1:0] flg;
    logic         wr;
  } alu_out_t;

  typedef struct packed {
    logic [W-1:0] res;
    logic         c;
    logic         h;
    logic         v;
  } sum_t;

  function automatic logic even_par(input logic [W-1:0] v);
    return ~^v;
  endfunction

  function automatic logic [W-1:0] mk_flags(input logic s, input logic z,
      input logic h, input logic p, input logic n, input logic c);
    logic [W-1:0] f;
    f     = '0;
    f[FS] = s;
    f[FZ] = z;
    f[FH] = h;
    f[FP] = p;
    f[FN] = n;
    f[FC] = c;
    return f;
  endfunction

  // add or subtract with carry/borrow in; carries reported as borrows for sub
  function automatic sum_t add_core(input logic [W-1:0] a, input logic [W-1:0] b,
      input logic cin, input logic sub);
    logic [W-1:0] bx;
    logic         cx;
    logic [HB:0]  lo;
    logic [W:0]   full;
    sum_t         s;
    bx    = sub ? ~b : b;
    cx    = sub ? ~cin : cin;
    lo    = {1'b0, a[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, cx};
    full  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cx};
    s.res = full[W-1:0];
    s.c   = full[W] ^ sub;
    s.h   = lo[HB] ^ sub;
    s.v   = (a[W-1] == bx[W-1]) && (s.res[W-1] != a[W-1]);
    return s;
  endfunction

  // returns {carry_out, result}
  function automatic logic [W:0] rot_core(input logic [2:0] code,
      input logic [W-1:0] a, input logic cin);
    case (code)
      3'd0:    return {a[W-1], a[W-2:0], a[W-1]};
      3'd1:    return {a[0], a[0], a[W-1:1]};
      3'd2:    return {a[W-1], a[W-2:0], cin};
      3'd3:    return {a[0], cin, a[W-1:1]};
      3'd4:    return {a[W-1], a[W-2:0], 1'b0};
      3'd5:    return {a[0], a[W-1], a[W-1:1]};
      3'd6:    return {a[W-1], a[W-2:0], 1'b1};
      default: return {a[0], 1'b0, a[W-1:1]};
    endcase
  endfunction
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [2:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] fin,
  output alu_out_t     out
);
  logic   is_sub;
  logic   cin;
  sum_t   s;
  logic [W-1:0] lr;

  assign is_sub = (sel == 3'd2) || (sel == 3'd3) || (sel == 3'd7);
  assign cin    = sel[0] && !sel[2] && fin[FC];
  assign s      = add_core(a, b, cin, is_sub);

  always_comb begin
    case (sel)
      3'd4:    lr = a & b;
      3'd5:    lr = a ^ b;
      default: lr = a | b;
    endcase
    if (sel[2] && sel != 3'd7) begin
      out.res = lr;
      out.flg = mk_flags(lr[W-1], lr == '0, sel == 3'd4, even_par(lr), 1'b0, 1'b0);
      out.wr  = 1'b1;
    end else begin
      out.res = s.res;
      out.flg = mk_flags(s.res[W-1], s.res == '0, s.h, s.v, is_sub, s.c);
      out.wr  = (sel != 3'd7);
    end
  end
endmodule

// File: rtl/alu8_misc.sv
`timescale 1ns/1ps
module alu8_misc
  import alu8_pkg::*;
(
  input  logic [2:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] fin,
  output alu_out_t     out
);
  localparam logic [HB-1:0] NIB_MAX = HB'(9);
  localparam logic [W:0]    LO_FIX  = (W+1)'(6);
  localparam logic [W-1:0]  HI_FIX  = W'(8'h60);

  logic         lo_fix;
  logic         hi_fix;
  logic [W:0]   t1;
  logic [W-1:0] daa_res;
  logic         daa_c;
  logic         daa_h;
  sum_t         neg;

  assign neg = add_core('0, a, 1'b0, 1'b1);

  always_comb begin
    lo_fix = (a[HB-1:0] > NIB_MAX) || fin[FH];
    t1     = {1'b0, a} + (lo_fix ? LO_FIX : '0);
    hi_fix = (t1[W:HB] > (W+1-HB)'(9)) || fin[FC];
    if (!fin[FN]) begin
      daa_res = t1[W-1:0] + (hi_fix ? HI_FIX : '0);
      daa_c   = fin[FC] | hi_fix;
      daa_h   = a[HB-1:0] > NIB_MAX;
    end else begin
      daa_res = a - (fin[FH] ? W'(6) : '0) - (fin[FC] ? HI_FIX : '0);
      daa_c   = fin[FC];
      daa_h   = fin[FH] && (a[HB-1:0] < HB'(6));
    end
  end

  always_comb begin
    out.res = a;
    out.flg = fin;
    out.wr  = 1'b1;
    case (sel)
      3'd0: begin
        out.res = daa_res;
        out.flg = mk_flags(daa_res[W-1], daa_res == '0, daa_h, even_par(daa_res),
                           fin[FN], daa_c);
      end
      3'd1: begin
        out.res     = ~a;
        out.flg[FH] = 1'b1;
        out.flg[FN] = 1'b1;
      end
      3'd2: begin
        out.res = neg.res;
        out.flg = mk_flags(neg.res[W-1], neg.res == '0, neg.h, neg.v, 1'b1, neg.c);
      end
      3'd3: begin
        out.flg[FC] = 1'b1;
        out.flg[FH] = 1'b0;
        out.flg[FN] = 1'b0;
      end
      3'd4: begin
        out.flg[FC] = ~fin[FC];
        out.flg[FH] = fin[FC];
        out.flg[FN] = 1'b0;
      end
      default: out.wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift
  import alu8_pkg::*;
(
  input  logic         is_cb,
  input  logic [2:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] fin,
  output alu_out_t     out
);
  logic [2:0] code;
  logic [W:0] rot;

  assign code = is_cb ? sel : {1'b0, sel[1:0]};
  assign rot  = rot_core(code, a, fin[FC]);

  always_comb begin
    out.res = rot[W-1:0];
    out.wr  = 1'b1;
    if (is_cb)
      out.flg = mk_flags(rot[W-1], rot[W-1:0] == '0, 1'b0, even_par(rot[W-1:0]),
                         1'b0, rot[W]);
    else
      out.flg = mk_flags(fin[FS], fin[FZ], 1'b0, fin[FP], 1'b0, rot[W]);
  end
endmodule

// File: rtl/alu8_bitop.sv
`timescale 1ns/1ps
module alu8_bitop
  import alu8_pkg::*;
(
  input  logic [1:0]    sel,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  fin,
  output alu_out_t      out
);
  logic [W-1:0] mask;

  assign mask = W'(1) << idx;

  always_comb begin
    out.res = a;
    out.flg = fin;
    out.wr  = 1'b1;
    case (sel)
      2'b01: begin
        out.flg[FZ] = (a & mask) == '0;
        out.flg[FH] = 1'b1;
        out.flg[FN] = 1'b0;
        out.wr      = 1'b0;
      end
      2'b10:   out.res = a & ~mask;
      2'b11:   out.res = a | mask;
      default: out.wr  = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_unit.sv
`timescale 1ns/1ps
module alu8_unit
  import alu8_pkg::*;
(
  input  logic [2:0]    op_grp,
  input  logic [2:0]    op_sel,
  input  logic [IW-1:0] bit_idx,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  flags_in,
  output logic [W-1:0]  result,
  output logic [W-1:0]  flags_out,
  output logic          wr_en
);
  alu_out_t arith_o;
  alu_out_t misc_o;
  alu_out_t shift_o;
  alu_out_t bit_o;
  alu_out_t pick;
  logic     grp_is_cb;

  assign grp_is_cb = (op_grp == GRP_SHIFT);

  alu8_arith i_arith (.sel(op_sel), .a(opa), .b(opb), .fin(flags_in), .out(arith_o));
  alu8_misc  i_misc  (.sel(op_sel), .a(opa), .fin(flags_in), .out(misc_o));
  alu8_shift i_shift (.is_cb(grp_is_cb), .sel(op_sel), .a(opa), .fin(flags_in),
                      .out(shift_o));
  alu8_bitop i_bitop (.sel(op_sel[1:0]), .idx(bit_idx), .a(opa), .fin(flags_in),
                      .out(bit_o));

  always_comb begin
    case (grp_e'(op_grp))
      GRP_ACC:              pick = arith_o;
      GRP_MISC:             pick = misc_o;
      GRP_AROT, GRP_SHIFT:  pick = shift_o;
      GRP_BIT:              pick = bit_o;
      default: begin
        pick.res = opa;
        pick.flg = flags_in;
        pick.wr  = 1'b0;
      end
    endcase
  end

  assign result    = pick.res;
  assign flags_out = pick.flg & FLAG_KEEP;
  assign wr_en     = pick.wr;
endmodule

// File: rtl/alu8_unit_chk.sv
`timescale 1ns/1ps
module alu8_unit_chk
  import alu8_pkg::*;
(
  input logic [2:0]    op_grp,
  input logic [2:0]    op_sel,
  input logic [IW-1:0] bit_idx,
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb,
  input logic [W-1:0]  flags_in,
  input logic [W-1:0]  result,
  input logic [W-1:0]  flags_out,
  input logic          wr_en
);
  logic known;
  assign known = !$isunknown({op_grp, op_sel, bit_idx, opa, opb, flags_in});

  always_comb begin
    if (known) begin
      AST_SPARE_FLAGS_ZERO: assert (flags_out[5] == 1'b0 && flags_out[3] == 1'b0); // R13
      AST_CP_NO_WRITE: assert (!(op_grp == 3'd0 && op_sel == 3'd7) || !wr_en); // R4
      AST_CP_ZERO_ON_EQUAL: assert (!(op_grp == 3'd0 && op_sel == 3'd7) || (flags_out[FZ] == (opa == opb))); // R4
      AST_LOGIC_NO_CARRY: assert (!(op_grp == 3'd0 && op_sel[2] && op_sel != 3'd7) || !flags_out[FC]); // R3
      AST_ACC_ZERO_FLAG: assert (op_grp != 3'd0 || flags_out[FZ] == (result == '0)); // R1
      AST_AROT_KEEPS_SZP: assert (op_grp != 3'd2 || (flags_out[FS] == flags_in[FS] && flags_out[FZ] == flags_in[FZ] && flags_out[FP] == flags_in[FP])); // R9
      AST_BIT_TEST_NO_WRITE: assert (!(op_grp == 3'd4 && op_sel[1:0] == 2'b01) || (!wr_en && result == opa)); // R11
      AST_BIT_SET_ONE: assert (!(op_grp == 3'd4 && op_sel[1:0] == 2'b11) || (result[bit_idx] && $countones(result ^ opa) <= 1)); // R12
    end
  end
endmodule

bind alu8_unit alu8_unit_chk i_chk (
  .op_grp(op_grp), .op_sel(op_sel), .bit_idx(bit_idx), .opa(opa), .opb(opb),
  .flags_in(flags_in), .result(result), .flags_out(flags_out), .wr_en(wr_en)
);

// File: tb/test_alu8_unit.sv
`timescale 1ns/1ps
module test_alu8_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_grp = '0;
  logic [2:0] op_sel = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic [7:0] flags_in = '0;
  logic [7:0] result;
  logic [7:0] flags_out;
  logic       wr_en;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  alu8_unit i_alu8_unit (
    .op_grp(op_grp), .op_sel(op_sel), .bit_idx(bit_idx), .opa(opa), .opb(opb),
    .flags_in(flags_in), .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  // {grp, sel, idx, a, b, fin, exp_res, exp_flags, exp_wr, req}
  localparam int NV = 34;
  localparam logic [53:0] VEC [NV] = '{
    {3'd0,3'd0,3'd0,8'h7F,8'h01,8'h00,8'h80,8'h94,1'b1,4'd1},  // R1 overflow, half
    {3'd0,3'd1,3'd0,8'hFF,8'h00,8'h01,8'h00,8'h51,1'b1,4'd1},  // R1 carry in
    {3'd0,3'd2,3'd0,8'h10,8'h01,8'h00,8'h0F,8'h12,1'b1,4'd2},  // R2 half borrow
    {3'd0,3'd3,3'd0,8'h00,8'h00,8'h01,8'hFF,8'h93,1'b1,4'd2},  // R2 borrow in
    {3'd0,3'd2,3'd0,8'h80,8'h01,8'h00,8'h7F,8'h16,1'b1,4'd2},  // R2 overflow
    {3'd0,3'd4,3'd0,8'hF0,8'h3C,8'h00,8'h30,8'h14,1'b1,4'd3},  // R3 and
    {3'd0,3'd5,3'd0,8'h55,8'h55,8'h01,8'h00,8'h44,1'b1,4'd3},  // R3 xor
    {3'd0,3'd6,3'd0,8'h01,8'h02,8'h00,8'h03,8'h04,1'b1,4'd3},  // R3 or
    {3'd0,3'd7,3'd0,8'h05,8'h05,8'h00,8'h00,8'h42,1'b0,4'd4},  // R4 compare
    {3'd1,3'd0,3'd0,8'h9A,8'h00,8'h00,8'h00,8'h55,1'b1,4'd5},  // R5 both fixes
    {3'd1,3'd0,3'd0,8'h15,8'h00,8'h10,8'h1B,8'h04,1'b1,4'd5},  // R5 half set
    {3'd1,3'd0,3'd0,8'h0F,8'h00,8'h12,8'h09,8'h06,1'b1,4'd6},  // R6 low fix
    {3'd1,3'd0,3'd0,8'hFF,8'h00,8'h13,8'h99,8'h87,1'b1,4'd6},  // R6 both fixes
    {3'd1,3'd1,3'd0,8'h5A,8'h00,8'h00,8'hA5,8'h12,1'b1,4'd7},  // R7 complement
    {3'd1,3'd2,3'd0,8'h01,8'h00,8'h00,8'hFF,8'h93,1'b1,4'd7},  // R7 negate
    {3'd1,3'd2,3'd0,8'h80,8'h00,8'h00,8'h80,8'h87,1'b1,4'd7},  // R7 negate overflow
    {3'd1,3'd3,3'd0,8'h33,8'h00,8'h12,8'h33,8'h01,1'b1,4'd8},  // R8 set carry
    {3'd1,3'd4,3'd0,8'h33,8'h00,8'h01,8'h33,8'h10,1'b1,4'd8},  // R8 flip carry
    {3'd2,3'd0,3'd0,8'h81,8'h00,8'hC4,8'h03,8'hC5,1'b1,4'd9},  // R9 circular left
    {3'd2,3'd3,3'd0,8'h01,8'h00,8'h00,8'h00,8'h01,1'b1,4'd9},  // R9 right through carry
    {3'd2,3'd2,3'd0,8'h80,8'h00,8'h01,8'h01,8'h01,1'b1,4'd9},  // R9 left through carry
    {3'd2,3'd1,3'd0,8'h02,8'h00,8'h00,8'h01,8'h00,1'b1,4'd9},  // R9 circular right
    {3'd3,3'd5,3'd0,8'h81,8'h00,8'h00,8'hC0,8'h85,1'b1,4'd10}, // R10 arith right
    {3'd3,3'd7,3'd0,8'h81,8'h00,8'h00,8'h40,8'h01,1'b1,4'd10}, // R10 logical right
    {3'd3,3'd6,3'd0,8'h80,8'h00,8'h00,8'h01,8'h01,1'b1,4'd10}, // R10 left one-in
    {3'd3,3'd4,3'd0,8'h80,8'h00,8'h00,8'h00,8'h45,1'b1,4'd10}, // R10 left zero-in
    {3'd3,3'd3,3'd0,8'h01,8'h00,8'h01,8'h80,8'h81,1'b1,4'd10}, // R10 right through carry
    {3'd4,3'd1,3'd3,8'hF7,8'h00,8'h01,8'hF7,8'h51,1'b0,4'd11}, // R11 tested bit zero
    {3'd4,3'd1,3'd7,8'h80,8'h00,8'h00,8'h80,8'h10,1'b0,4'd11}, // R11 tested bit one
    {3'd4,3'd2,3'd0,8'hFF,8'h00,8'h85,8'hFE,8'h85,1'b1,4'd12}, // R12 clear
    {3'd4,3'd3,3'd6,8'h00,8'h00,8'h00,8'h40,8'h00,1'b1,4'd12}, // R12 set
    {3'd7,3'd0,3'd0,8'h3C,8'h00,8'hFF,8'h3C,8'hD7,1'b0,4'd13}, // R13 undefined group
    {3'd1,3'd5,3'd0,8'h3C,8'h00,8'h28,8'h3C,8'h00,1'b0,4'd13}, // R13 undefined misc
    {3'd4,3'd0,3'd2,8'h3C,8'h00,8'hC5,8'h3C,8'hC5,1'b0,4'd13}  // R13 bit code 00
  };

  function automatic logic [7:0] fl(bit s, bit z, bit h, bit p, bit n, bit c);
    return {s, z, 1'b0, h, 1'b0, p, n, c};
  endfunction

  function automatic bit par_even(int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    return (ones % 2) == 0;
  endfunction

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic logic [16:0] m_acc(int sel, int a, int b, int fin);
    int ci, r, sv;
    bit c, h, v, sub;
    if (sel >= 4 && sel <= 6) begin
      r = (sel == 4) ? (a & b) : (sel == 5) ? (a ^ b) : (a | b);
      return {8'(r), fl(r > 127, r == 0, sel == 4, par_even(r), 1'b0, 1'b0), 1'b1};
    end
    ci  = (sel == 1 || sel == 3) ? (fin & 1) : 0;
    sub = (sel == 2 || sel == 3 || sel == 7);
    if (!sub) begin
      r = a + b + ci; c = r > 255; h = ((a & 15) + (b & 15) + ci) > 15; sv = sx(a) + sx(b) + ci;
    end else begin
      r = a - b - ci; c = r < 0; h = ((a & 15) - (b & 15) - ci) < 0; sv = sx(a) - sx(b) - ci;
    end
    v = (sv > 127) || (sv < -128);
    r = r & 255;
    return {8'(r), fl(r > 127, r == 0, h, v, sub, c), sel != 7};
  endfunction

  function automatic logic [16:0] m_daa(int a, int fin);
    int t, r;
    bit lo, hi, c, h;
    if ((fin & 2) == 0) begin
      lo = ((a & 15) > 9) || ((fin & 16) != 0);
      t  = a + (lo ? 6 : 0);
      hi = ((t >> 4) > 9) || ((fin & 1) != 0);
      r  = (t + (hi ? 96 : 0)) & 255;
      c  = ((fin & 1) != 0) || hi;
      h  = (a & 15) > 9;
    end else begin
      r  = (a - (((fin & 16) != 0) ? 6 : 0) - (((fin & 1) != 0) ? 96 : 0)) & 255;
      c  = (fin & 1) != 0;
      h  = ((fin & 16) != 0) && ((a & 15) < 6);
    end
    return {8'(r), fl(r > 127, r == 0, h, par_even(r), (fin & 2) != 0, c), 1'b1};
  endfunction

  function automatic logic [16:0] m_shift(int code, int a, int fin, bit cb);
    int r, ci;
    bit c;
    ci = fin & 1;
    case (code)
      0: begin r = ((a << 1) | (a >> 7)) & 255; c = (a >> 7) & 1; end
      1: begin r = (a >> 1) | ((a & 1) << 7);   c = a & 1; end
      2: begin r = ((a << 1) | ci) & 255;       c = (a >> 7) & 1; end
      3: begin r = (a >> 1) | (ci << 7);        c = a & 1; end
      4: begin r = (a << 1) & 255;              c = (a >> 7) & 1; end
      5: begin r = (a >> 1) | (a & 128);        c = a & 1; end
      6: begin r = ((a << 1) | 1) & 255;        c = (a >> 7) & 1; end
      default: begin r = a >> 1;                c = a & 1; end
    endcase
    if (cb) return {8'(r), fl(r > 127, r == 0, 1'b0, par_even(r), 1'b0, c), 1'b1};
    return {8'(r), fl((fin & 128) != 0, (fin & 64) != 0, 1'b0, (fin & 4) != 0, 1'b0, c), 1'b1};
  endfunction

  task automatic apply(input logic [2:0] g, input logic [2:0] s, input logic [2:0] i,
                       input logic [7:0] a, input logic [7:0] b, input logic [7:0] f);
    @(negedge clk);
    op_grp = g; op_sel = s; bit_idx = i; opa = a; opb = b; flags_in = f;
    #5;
  endtask

  task automatic check(input logic [16:0] exp, input int req);
    checks++;
    if ({result, flags_out, wr_en} !== exp) begin
      failures++;
      $display("FAIL R%0d grp=%0d sel=%0d idx=%0d a=%h b=%h fin=%h: got res=%h flg=%h wr=%b expected res=%h flg=%h wr=%b",
               req, op_grp, op_sel, bit_idx, opa, opb, flags_in,
               result, flags_out, wr_en, exp[16:9], exp[8:1], exp[0]);
    end
  endtask

  initial begin
    // reset period: all inputs zero is an add of 0 + 0 (R1)
    repeat (3) @(posedge clk);
    @(negedge clk); #5;
    check({8'h00, 8'h40, 1'b1}, 1);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      apply(VEC[n][53:51], VEC[n][50:48], VEC[n][47:45], VEC[n][44:37], VEC[n][36:29], VEC[n][28:21]);
      check({VEC[n][20:13], VEC[n][12:5], VEC[n][4]}, int'(VEC[n][3:0]));
    end

    // R1 R2 R3 R4: accumulator group sweep
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 2; k++)
          for (int c = 0; c < 2; c++) begin
            int b = (a * 37 + k * 101 + s) & 255;
            apply(3'd0, 3'(s), 3'd0, 8'(a), 8'(b), 8'(c | (k << 4)));
            check(m_acc(s, a, b, c), (s < 2) ? 1 : (s < 4) ? 2 : (s < 7) ? 3 : 4);
          end

    // R5 R6: decimal adjust for every operand and N/H/C combination
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 8; f++) begin
        int fin = ((f & 4) ? 16 : 0) | ((f & 2) ? 2 : 0) | (f & 1);
        apply(3'd1, 3'd0, 3'd0, 8'(a), 8'h00, 8'(fin));
        check(m_daa(a, fin), ((fin & 2) != 0) ? 6 : 5);
      end

    // R7: negate against the subtract model
    for (int a = 0; a < 256; a++) begin
      apply(3'd1, 3'd2, 3'd0, 8'(a), 8'h00, 8'h00);
      check(m_acc(2, 0, a, 0), 7);
    end

    // R9 R10: rotates and shifts
    for (int code = 0; code < 8; code++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++) begin
          apply(3'd3, 3'(code), 3'd0, 8'(a), 8'h00, 8'(c));
          check(m_shift(code, a, c, 1'b1), 10);
          if (code < 4) begin
            apply(3'd2, 3'(code), 3'd0, 8'(a), 8'h00, 8'(c | (a & 8'hC4)));
            check(m_shift(code, a, c | (a & 8'hC4), 1'b0), 9);
          end
        end

    // R11 R12: all bit positions
    for (int i = 0; i < 8; i++)
      for (int a = 0; a < 256; a += 3) begin
        apply(3'd4, 3'd1, 3'(i), 8'(a), 8'h00, 8'h81);
        check({8'(a), fl(1'b1, ((a >> i) & 1) == 0, 1'b1, 1'b0, 1'b0, 1'b1), 1'b0}, 11);
        apply(3'd4, 3'd2, 3'(i), 8'(a), 8'h00, 8'h45);
        check({8'(a & ~(1 << i)), 8'h45, 1'b1}, 12);
        apply(3'd4, 3'd3, 3'(i), 8'(a), 8'h00, 8'h12);
        check({8'(a | (1 << i)), 8'h12, 1'b1}, 12);
      end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule